// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A transmit buffer offers bytes through a valid/ready handshake. For each byte the block sends a low start bit, 5 to 8 data bits least significant first, an optional parity bit and one or two high stop bits. An 8-bit line-control word sets the frame format. Every bit lasts 16 pulses of an oversampled baud tick, so the bit rate comes entirely from the tick source.

The format is taken from the line-control word when a byte is accepted, and it stays fixed until that frame ends. A forced-break field is the only field that acts at once: it pulls the line low whenever it is set. Bytes are accepted only when the global enable and the transmit enable are both high. A busy output covers every bit of a frame, from the start bit to the end of the last stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is active and break is clear, `tx_o` is high and `busy_o` is low.
- R2: A frame begins with a low start bit in the cycle after the accepting edge. Data bits follow least significant first. Each bit lasts exactly 16 cycles in which `tick16_i` is high.
- R3: `line_ctrl_i[6:5]` gives the word length minus 5 (00 = 5 bits, 11 = 8 bits). Data bits above the word length are not sent.
- R4: When `line_ctrl_i[1]` is set, a parity bit follows the data. If `line_ctrl_i[2]` is set, the data bits plus the parity bit hold an even number of ones; if it is clear, they hold an odd number.
- R5: When `line_ctrl_i[7]` and `line_ctrl_i[1]` are both set, the parity bit is fixed: 0 if `line_ctrl_i[2]` is set and 1 if it is clear, whatever the data.
- R6: When `line_ctrl_i[3]` is set, the frame ends with two high stop bits; when it is clear, with one.
- R7: While `line_ctrl_i[0]` is set, `tx_o` is low, both when idle and in the middle of a frame.
- R8: A byte is accepted only when `en_i`, `tx_en_i` and `valid_i` are all high and no frame is active. `ready_o` is high exactly in that idle and enabled state.
- R9: `busy_o` rises on the accepting edge, stays high through the last stop bit and falls when the frame ends.
- R10: The format fields are captured at acceptance. A change to `line_ctrl_i` during a frame does not change that frame's format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle pulse at 16 times the baud rate |
| data_i | input | 8 | Byte offered for transmission |
| valid_i | input | 1 | `data_i` is valid |
| ready_o | output | 1 | Byte is taken on this edge if valid |
| line_ctrl_i | input | 8 | Line-control word: break, parity enable, even select, two stop, word length, stick |
| en_i | input | 1 | Global enable |
| tx_en_i | input | 1 | Transmit enable |
| tx_o | output | 1 | Serial output line |
| busy_o | output | 1 | A frame is being sent |

## Verification
The bench sends frames that cover each word length, no parity, even, odd and both stick values, and one or two stop bits. The data is chosen so that every parity mode gives a bit that differs from the result of the wrong mode, and so that a 5-bit frame carries high bits that must be dropped. Frames run with the tick on every cycle and also with the tick spread over two and three cycles. Each run checks the whole bit sequence, so an off-by-one bit width shows up as a wrong sample. Other runs change the control word mid-frame, assert break both when idle and inside a frame, and hold each enable low by itself with a byte pending.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef struct packed {
    logic       stick;
    logic [1:0] wlen;
    logic       rsvd;
    logic       two_stop;
    logic       even;
    logic       par_en;
    logic       brk;
  } line_ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_done_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q;

  assign bit_done_o = run_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= bit_done_o ? '0 : cnt_q + 1'b1;
  end

  // bit length counts only tick pulses
  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    wlen_i,
  input  logic          even_i,
  input  logic          stick_i,
  output logic          par_o
);
  localparam int NMIN = DW - 3;

  logic [DW-1:0] keep;
  logic          ones_odd;

  for (genvar i = 0; i < DW; i++) begin : g_keep
    assign keep[i] = (i < NMIN) || (int'(wlen_i) >= i - NMIN + 1);
  end

  assign ones_odd = ^(data_i & keep);

  always_comb begin
    if (stick_i)     par_o = ~even_i;
    else if (even_i) par_o = ones_odd;
    else             par_o = ~ones_odd;
  end

endmodule

// File: rtl/uart_tx_frame_ctl.sv
module uart_tx_frame_ctl
  import uart_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  line_ctrl_t    ctrl_i,
  output logic          ready_o,
  output logic          busy_o,
  output logic          line_o
);
  localparam int IW   = $clog2(DW);
  localparam int NMIN = DW - 3;

  tx_state_e     state_q;
  logic [DW-1:0] shift_q;
  logic [IW-1:0] idx_q;
  logic [1:0]    wlen_q;
  logic          pen_q, stp2_q, par_q;
  logic          par_now, bit_done, accept;
  logic [IW-1:0] last_idx;

  assign ready_o  = (state_q == ST_IDLE) && en_i;
  assign accept   = ready_o && valid_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign last_idx = IW'(wlen_q) + IW'(NMIN - 1);

  uart_tx_parity #(.DW(DW)) u_par (
    .data_i  (data_i),
    .wlen_i  (ctrl_i.wlen),
    .even_i  (ctrl_i.even),
    .stick_i (ctrl_i.stick),
    .par_o   (par_now)
  );

  uart_tx_bit_timer #(.OSR(OSR)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .run_i      (busy_o),
    .tick_i     (tick_i),
    .bit_done_o (bit_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      idx_q   <= '0;
      wlen_q  <= '0;
      pen_q   <= 1'b0;
      stp2_q  <= 1'b0;
      par_q   <= 1'b0;
    end else if (accept) begin
      state_q <= ST_START;
      shift_q <= data_i;
      idx_q   <= '0;
      wlen_q  <= ctrl_i.wlen;
      pen_q   <= ctrl_i.par_en;
      stp2_q  <= ctrl_i.two_stop;
      par_q   <= par_now;
    end else if (bit_done) begin
      unique case (state_q)
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          if (idx_q == last_idx) begin
            idx_q   <= '0;
            state_q <= pen_q ? ST_PAR : ST_STOP;
          end else begin
            idx_q   <= idx_q + 1'b1;
            shift_q <= shift_q >> 1;
          end
        end
        ST_PAR: state_q <= ST_STOP;
        ST_STOP: begin
          if (stp2_q && idx_q == '0) idx_q <= 1'b1;
          else begin
            idx_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shift_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  p_ready_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (en_i && !busy_o));
  p_busy_on_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !line_o);
  p_fmt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !accept) |=> $stable({wlen_q, pen_q, stp2_q, par_q}));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic [7:0]    line_ctrl_i,
  input  logic          en_i,
  input  logic          tx_en_i,
  output logic          tx_o,
  output logic          busy_o
);
  line_ctrl_t ctrl;
  logic       line_bit;
  logic       unused_rsvd;

  assign ctrl        = line_ctrl_t'(line_ctrl_i);
  assign unused_rsvd = ctrl.rsvd;

  uart_tx_frame_ctl #(.DW(DW), .OSR(OSR)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick16_i),
    .en_i    (en_i & tx_en_i),
    .valid_i (valid_i),
    .data_i  (data_i),
    .ctrl_i  (ctrl),
    .ready_o (ready_o),
    .busy_o  (busy_o),
    .line_o  (line_bit)
  );

  // break overrides the line immediately
  assign tx_o = line_bit & ~ctrl.brk;

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !line_ctrl_i[0]) |-> tx_o);
  p_break_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_ctrl_i[0] |-> !tx_o);
  p_enable_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || !tx_en_i) |-> !ready_o);

endmodule

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] data = '0;
  logic       valid = 1'b0;
  logic       ready;
  logic [7:0] lctl = '0;
  logic       en = 1'b0, tx_en = 1'b0;
  logic       tx, busy;

  int checks = 0, fails = 0;
  int tick_p = 1, tcnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= tick_p - 1) begin tcnt = 0; tick = 1'b1; end
    else begin tcnt = tcnt + 1; tick = 1'b0; end
  end

  uart_frame_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .data_i(data),
    .valid_i(valid), .ready_o(ready), .line_ctrl_i(lctl), .en_i(en),
    .tx_en_i(tx_en), .tx_o(tx), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // frame run: c at accept, c_mid applied after accept
  task automatic run_frame(input logic [7:0] d, input logic [7:0] c,
                           input logic [7:0] c_mid, input int p, input string req);
    logic [11:0] expv = '0, gotv = '0;
    int n = 0, nd;
    logic x, pb, busy_mid;
    nd = int'(c[6:5]) + 5;
    expv[n++] = 1'b0;
    x = 1'b0;
    for (int i = 0; i < nd; i++) begin expv[n++] = d[i]; x ^= d[i]; end
    if (c[1]) begin
      pb = c[7] ? ~c[2] : (c[2] ? x : ~x);
      expv[n++] = pb;
    end
    expv[n++] = 1'b1;
    if (c[3]) expv[n++] = 1'b1;
    tick_p = p;
    @(negedge clk);
    lctl = c; data = d; valid = 1'b1;
    chk(ready === 1'b1, "R8", "ready before accept", 16'(ready), 16'h1);
    @(negedge clk);
    valid = 1'b0; lctl = c_mid;
    busy_mid = 1'b0;
    for (int k = 0; k < n; k++) begin
      repeat (k == 0 ? 8 * p : 16 * p) @(negedge clk);
      gotv[k] = tx;
      if (k == n - 1) busy_mid = busy;
    end
    chk(gotv === expv, req, "frame bits", 16'(gotv), 16'(expv));
    chk(busy_mid === 1'b1, "R9", "busy in last stop", 16'(busy_mid), 16'h1);
    repeat (8 * p + 1) @(negedge clk);
    chk(busy === 1'b0 && tx === 1'b1, "R9", "idle after frame",
        {14'd0, busy, tx}, 16'h1);
  endtask

  task automatic t_reset;
    chk(tx === 1'b1 && busy === 1'b0 && ready === 1'b0, "R1", "reset state",
        {13'd0, tx, busy, ready}, 16'h4);
  endtask

  task automatic t_gate(input logic e, input logic te);
    bit bad = 0;
    @(negedge clk);
    en = e; tx_en = te; lctl = 8'h60; data = 8'h55; valid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ready !== 1'b0 || tx !== 1'b1 || busy !== 1'b0) bad = 1;
    end
    chk(!bad, "R8", "no accept while disabled", 16'(bad), 16'h0);
    valid = 1'b0; en = 1'b1; tx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_break_idle;
    @(negedge clk); lctl = 8'h61;
    @(negedge clk);
    chk(tx === 1'b0 && busy === 1'b0, "R7", "idle break low",
        {14'd0, tx, busy}, 16'h0);
    lctl = 8'h60;
    @(negedge clk);
    chk(tx === 1'b1, "R1", "line high after break", 16'(tx), 16'h1);
  endtask

  task automatic t_break_frame;
    logic s3, s9, b9;
    tick_p = 1;
    @(negedge clk); lctl = 8'h60; data = 8'hFF; valid = 1'b1;
    @(negedge clk); valid = 1'b0; lctl = 8'h61;
    repeat (8 + 16 * 3) @(negedge clk); s3 = tx;
    repeat (16 * 6) @(negedge clk); s9 = tx; b9 = busy;
    chk(s3 === 1'b0 && s9 === 1'b0, "R7", "break in frame",
        {14'd0, s3, s9}, 16'h0);
    chk(b9 === 1'b1, "R10", "frame continues under break", 16'(b9), 16'h1);
    lctl = 8'h60;
    repeat (9) @(negedge clk);
    chk(busy === 1'b0 && tx === 1'b1, "R9", "idle after break frame",
        {14'd0, busy, tx}, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate(1'b1, 1'b0);
    t_gate(1'b0, 1'b1);
    run_frame(8'hA5, 8'h60, 8'h60, 1, "R2");          // 8N1
    run_frame(8'hFB, 8'h06, 8'h06, 1, "R3");          // 5E1, high bits dropped
    run_frame(8'h35, 8'h4A, 8'h4A, 3, "R4");          // 7O2 odd parity, slow tick
    run_frame(8'h80, 8'h6E, 8'h6E, 2, "R6");          // 8E2
    run_frame(8'h2C, 8'hA6, 8'hA6, 1, "R5");          // stick 0
    run_frame(8'h2C, 8'hA2, 8'hA2, 1, "R5");          // stick 1
    run_frame(8'h3C, 8'h60, 8'h0E, 1, "R10");         // mid-frame change
    t_break_idle();
    t_break_frame();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule